// File: doc/BRIEF.md
# Trap Return Privilege Sequencer

This block carries out the two trap-return operations of a processor core: the return from a machine-level trap and the return from a supervisor-level trap. For each request it decides whether the return is allowed at the current privilege and whether the return address may be fetched. If both checks pass, it computes the privilege level to resume in and the machine status word with the interrupt-enable stack popped. It also produces the return address taken from the matching exception PC register.

A request is presented with `req_valid` together with its kind, the current privilege, the status word, both exception PC values and the compressed-instruction flag. All of these are sampled on the accepting clock edge. The result is registered and appears with `res_valid` for exactly one cycle after that edge. While the result is on the outputs, `req_ready` is low, so a caller that holds its request waits one cycle. Writing the status word back into the register file and redirecting instruction fetch are left to the surrounding core.

Top module: `trapret_seq`

## Requirements
- R1: `req_ready` is high whenever no result is being presented. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. An accepted request gives `res_valid` high for exactly the following cycle, and `req_ready` is low during that cycle, so a held request is accepted one cycle later.
- R2: `ret_pc` is `sepc` for a supervisor return (`req_kind`=0) and `mepc` for a machine return (`req_kind`=1). This holds whether or not a fault is reported.
- R3: Privilege encoding is user=0, supervisor=1, reserved=2, machine=3. A supervisor return needs `cur_priv` of at least 1, and a machine return needs `cur_priv`=3. Otherwise `exc_illegal`=1, `new_priv` equals the sampled `cur_priv`, and `status_out` equals the sampled `status_in`.
- R4: When `has_compressed`=0 and bits [1:0] of the return address are nonzero, `exc_misaligned`=1 and, as for R3, the privilege and status are passed through unchanged. When `has_compressed`=1, no alignment fault is raised. An illegal return takes priority, so the two fault flags are never both high.
- R5: On a successful machine return, status bit 3 (machine IE) takes the old bit 7 (machine previous IE), bit 7 is cleared, and bits [12:11] (machine previous privilege) become 0.
- R6: On a successful supervisor return, status bit 1 (supervisor IE) takes the old bit 5 (supervisor previous IE), bit 5 is cleared, and bit 8 (supervisor previous privilege) becomes 0.
- R7: On success, `new_priv` comes from bits [12:11] for a machine return and from {0, bit 8} for a supervisor return. A previous-privilege value of 2 yields user (0), so `new_priv` is never 2 after a successful return.
- R8: On success, every status bit not named in R5 or R6 for that return kind passes to `status_out` unchanged. The IE and previous-IE updates use the status value sampled with the request.
- R9: After reset, `res_valid`, `exc_illegal` and `exc_misaligned` are 0, `req_ready` is 1, and `new_priv`, `status_out` and `ret_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Return request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 1 | 0 = supervisor return, 1 = machine return |
| cur_priv | input | 2 | Current privilege level |
| status_in | input | XLEN | Machine status word before the return |
| mepc | input | XLEN | Machine exception PC |
| sepc | input | XLEN | Supervisor exception PC |
| has_compressed | input | 1 | Compressed instructions supported (2-byte alignment allowed) |
| res_valid | output | 1 | Result valid this cycle |
| new_priv | output | 2 | Privilege to resume in |
| status_out | output | XLEN | Status word after the return |
| ret_pc | output | XLEN | Return address |
| exc_illegal | output | 1 | Illegal-instruction fault |
| exc_misaligned | output | 1 | Instruction-address-misaligned fault |

## Verification
A wrong privilege decision shows up in the single result cycle after the request. It appears as a missing or spurious `exc_illegal`, and with it as a status word that was modified when it should have stayed frozen. A mistaken interrupt-enable stack update shows up in the same cycle as a wrong bit 1, 3, 5, 7, 8 or 11–12 of `status_out`, or as a corrupted neighbouring bit. A failure of the reserved-mode remap shows as `new_priv`=2. A broken acceptance register is visible within two cycles, either as a result that lasts more than one cycle or as `req_ready` staying high while a result is presented.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic {
        RET_SUPER = 1'b0,
        RET_MACH  = 1'b1
    } ret_kind_e;

    // Status word field positions (decoded by the rest of the core)
    localparam int SIE_POS  = 1;
    localparam int MIE_POS  = 3;
    localparam int SPIE_POS = 5;
    localparam int MPIE_POS = 7;
    localparam int SPP_POS  = 8;
    localparam int MPP_LO   = 11;
    localparam int MPP_HI   = 12;
    localparam int STATUS_MIN_W = MPP_HI + 1;

    typedef struct packed {
        logic illegal;
        logic misaligned;
    } fault_t;

    // Lowest privilege allowed to issue a given return kind
    function automatic priv_e min_priv(ret_kind_e kind);
        return (kind == RET_MACH) ? PRIV_MACH : PRIV_SUPER;
    endfunction

    // The reserved level never becomes the running privilege
    function automatic priv_e remap_priv(logic [1:0] pp);
        return (pp == 2'd2) ? PRIV_USER : priv_e'(pp);
    endfunction

endpackage

// File: rtl/trapret_check.sv
module trapret_check
    import trapret_pkg::*;
#(
    parameter int ALIGN_BITS = 2
) (
    input  ret_kind_e             kind,
    input  logic [1:0]            cur_priv,
    input  logic                  has_compressed,
    input  logic [ALIGN_BITS-1:0] pc_low,
    output fault_t                fault
);
    logic priv_low;
    logic align_bad;

    assign priv_low = (cur_priv < 2'(min_priv(kind)));

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign align_bad = !has_compressed && (pc_low != '0);
        end else begin : g_noalign
            assign align_bad = 1'b0;
        end
    endgenerate

    always_comb begin
        fault.illegal    = priv_low;
        fault.misaligned = !priv_low && align_bad;
    end

    // R4
    always_comb begin
        fault_prio_chk: assert (!(fault.illegal && fault.misaligned));
    end
endmodule

// File: rtl/trapret_pcsel.sv
module trapret_pcsel
    import trapret_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ret_kind_e       kind,
    input  logic [XLEN-1:0] mepc,
    input  logic [XLEN-1:0] sepc,
    output logic [XLEN-1:0] pc
);
    always_comb begin
        unique case (kind)
            RET_MACH:  pc = mepc;
            default:   pc = sepc;
        endcase
    end
endmodule

// File: rtl/trapret_status.sv
module trapret_status
    import trapret_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ret_kind_e       kind,
    input  logic [XLEN-1:0] status_in,
    output logic [XLEN-1:0] status_next,
    output priv_e           priv_next
);
    always_comb begin
        status_next = status_in;
        if (kind == RET_MACH) begin
            priv_next                    = remap_priv(status_in[MPP_HI:MPP_LO]);
            status_next[MIE_POS]         = status_in[MPIE_POS];
            status_next[MPIE_POS]        = 1'b0;
            status_next[MPP_HI:MPP_LO]   = 2'(PRIV_USER);
        end else begin
            priv_next                    = remap_priv({1'b0, status_in[SPP_POS]});
            status_next[SIE_POS]         = status_in[SPIE_POS];
            status_next[SPIE_POS]        = 1'b0;
            status_next[SPP_POS]         = 1'b0;
        end
    end
endmodule

// File: rtl/trapret_seq.sv
module trapret_seq
    import trapret_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_kind,
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] status_in,
    input  logic [XLEN-1:0] mepc,
    input  logic [XLEN-1:0] sepc,
    input  logic            has_compressed,
    output logic            res_valid,
    output logic [1:0]      new_priv,
    output logic [XLEN-1:0] status_out,
    output logic [XLEN-1:0] ret_pc,
    output logic            exc_illegal,
    output logic            exc_misaligned
);
    localparam int PC_ALIGN = (ALIGN_BITS > 0) ? ALIGN_BITS : 1;

    ret_kind_e       kind;
    logic [XLEN-1:0] pc_sel;
    logic [XLEN-1:0] status_next;
    priv_e           priv_next;
    fault_t          fault;
    logic            accept;

    logic            valid_q;
    logic [1:0]      priv_q;
    logic [XLEN-1:0] status_q;
    logic [XLEN-1:0] pc_q;
    fault_t          fault_q;

    assign kind = ret_kind_e'(req_kind);

    trapret_pcsel #(.XLEN(XLEN)) u_pcsel (
        .kind (kind),
        .mepc (mepc),
        .sepc (sepc),
        .pc   (pc_sel)
    );

    trapret_check #(.ALIGN_BITS(PC_ALIGN)) u_check (
        .kind           (kind),
        .cur_priv       (cur_priv),
        .has_compressed (has_compressed),
        .pc_low         (pc_sel[PC_ALIGN-1:0]),
        .fault          (fault)
    );

    trapret_status #(.XLEN(XLEN)) u_status (
        .kind        (kind),
        .status_in   (status_in),
        .status_next (status_next),
        .priv_next   (priv_next)
    );

    assign req_ready = !valid_q;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            priv_q   <= '0;
            status_q <= '0;
            pc_q     <= '0;
            fault_q  <= '0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                pc_q    <= pc_sel;
                fault_q <= fault;
                if (fault.illegal || fault.misaligned) begin
                    priv_q   <= cur_priv;
                    status_q <= status_in;
                end else begin
                    priv_q   <= 2'(priv_next);
                    status_q <= status_next;
                end
            end
        end
    end

    assign res_valid      = valid_q;
    assign new_priv       = priv_q;
    assign status_out     = status_q;
    assign ret_pc         = pc_q;
    assign exc_illegal    = fault_q.illegal;
    assign exc_misaligned = fault_q.misaligned;

    // R1
    accept_result_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> res_valid);
    // R1
    single_result_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    // R1
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !req_ready);
    // R3
    illegal_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && exc_illegal) |->
        (status_out == $past(status_in) && new_priv == $past(cur_priv)));
    // R4
    fault_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !(exc_illegal && exc_misaligned));
    // R7
    no_reserved_priv_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !exc_illegal && !exc_misaligned) |-> (new_priv != 2'd2));
    // R5
    mret_pp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !exc_illegal && !exc_misaligned && $past(req_kind)) |->
        (status_out[MPP_HI:MPP_LO] == 2'd0 && !status_out[MPIE_POS]));
endmodule

// File: tb/trapret_seq_test.sv
module trapret_seq_test;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid;
    logic            req_ready;
    logic            req_kind;
    logic [1:0]      cur_priv;
    logic [XLEN-1:0] status_in;
    logic [XLEN-1:0] mepc;
    logic [XLEN-1:0] sepc;
    logic            has_compressed;
    logic            res_valid;
    logic [1:0]      new_priv;
    logic [XLEN-1:0] status_out;
    logic [XLEN-1:0] ret_pc;
    logic            exc_illegal;
    logic            exc_misaligned;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trapret_seq #(.XLEN(XLEN)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .cur_priv(cur_priv), .status_in(status_in),
        .mepc(mepc), .sepc(sepc), .has_compressed(has_compressed),
        .res_valid(res_valid), .new_priv(new_priv), .status_out(status_out),
        .ret_pc(ret_pc), .exc_illegal(exc_illegal), .exc_misaligned(exc_misaligned)
    );

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Expected results from the requirements
    task automatic model(input logic kind, input logic [1:0] cur,
                         input logic [XLEN-1:0] st, input logic [XLEN-1:0] mp,
                         input logic [XLEN-1:0] sp, input logic hc,
                         output logic [1:0] e_pr, output logic [XLEN-1:0] e_st,
                         output logic [XLEN-1:0] e_pc, output logic e_ill,
                         output logic e_mis);
        logic [1:0] pp;
        e_pc  = kind ? mp : sp;
        e_ill = kind ? (cur != 2'd3) : (cur == 2'd0);
        e_mis = !e_ill && !hc && (e_pc[1:0] != 2'b00);
        e_st  = st;
        e_pr  = cur;
        if (!e_ill && !e_mis) begin
            if (kind) begin
                pp = st[12:11];
                e_pr = (pp == 2'd2) ? 2'd0 : pp;
                e_st[3] = st[7];
                e_st[7] = 1'b0;
                e_st[12:11] = 2'd0;
            end else begin
                e_pr = {1'b0, st[8]};
                e_st[1] = st[5];
                e_st[5] = 1'b0;
                e_st[8] = 1'b0;
            end
        end
    endtask

    task automatic drive(input logic kind, input logic [1:0] cur,
                         input logic [XLEN-1:0] st, input logic [XLEN-1:0] mp,
                         input logic [XLEN-1:0] sp, input logic hc);
        req_valid = 1'b1;
        req_kind = kind; cur_priv = cur; status_in = st;
        mepc = mp; sepc = sp; has_compressed = hc;
    endtask

    task automatic compare(input string req, input logic kind, input logic [1:0] cur,
                           input logic [XLEN-1:0] st, input logic [XLEN-1:0] mp,
                           input logic [XLEN-1:0] sp, input logic hc);
        logic [1:0] e_pr; logic [XLEN-1:0] e_st; logic [XLEN-1:0] e_pc;
        logic e_ill; logic e_mis;
        model(kind, cur, st, mp, sp, hc, e_pr, e_st, e_pc, e_ill, e_mis);
        chk(req, "res_valid", XLEN'(res_valid), 1);
        chk(req, "new_priv", XLEN'(new_priv), XLEN'(e_pr));
        chk(req, "status_out", status_out, e_st);
        chk("R2", "ret_pc", ret_pc, e_pc);
        chk(req, "exc_illegal", XLEN'(exc_illegal), XLEN'(e_ill));
        chk("R4", "exc_misaligned", XLEN'(exc_misaligned), XLEN'(e_mis));
    endtask

    // One request, accepted at the next edge, checked in the result cycle
    task automatic one_return(input string req, input logic kind, input logic [1:0] cur,
                              input logic [XLEN-1:0] st, input logic [XLEN-1:0] mp,
                              input logic [XLEN-1:0] sp, input logic hc);
        @(negedge clk);
        drive(kind, cur, st, mp, sp, hc);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        compare(req, kind, cur, st, mp, sp, hc);
    endtask

    task automatic t_reset;
        chk("R9", "res_valid", XLEN'(res_valid), 0);
        chk("R9", "req_ready", XLEN'(req_ready), 1);
        chk("R9", "faults", XLEN'({exc_illegal, exc_misaligned}), 0);
        chk("R9", "outputs", status_out | ret_pc | XLEN'(new_priv), 0);
    endtask

    task automatic t_mret;
        // R5 R7 R8: MPP=S, MPIE=1, other bits patterned
        one_return("R5", 1'b1, 2'd3, 32'hA5A0_0880 | 32'h0000_0080, 32'h0000_1000, 32'h0000_2000, 1'b0);
        // R7: MPP reserved (2) remaps to user
        one_return("R7", 1'b1, 2'd3, 32'h0000_1000, 32'h0000_3004, 32'h0, 1'b0);
        // R8: MPP=M, MPIE=0, MIE=1, all other bits set
        one_return("R8", 1'b1, 2'd3, 32'hFFFF_FF7F, 32'h0000_4008, 32'h0, 1'b0);
    endtask

    task automatic t_sret;
        // R6: SPP=1, SPIE=0, SIE=1
        one_return("R6", 1'b0, 2'd1, 32'h0000_0102, 32'h0, 32'h0000_5000, 1'b0);
        // R6 R7: SPP=0, SPIE=1, issued from machine
        one_return("R7", 1'b0, 2'd3, 32'h5A5A_1820, 32'h0, 32'h0000_6000, 1'b0);
    endtask

    task automatic t_illegal;
        one_return("R3", 1'b1, 2'd1, 32'h0000_1888, 32'h0000_7000, 32'h0, 1'b0);
        one_return("R3", 1'b0, 2'd0, 32'h0000_0122, 32'h0, 32'h0000_7100, 1'b0);
        // illegal beats misaligned
        one_return("R4", 1'b1, 2'd0, 32'h0000_0080, 32'h0000_7002, 32'h0, 1'b0);
    endtask

    task automatic t_align;
        one_return("R4", 1'b1, 2'd3, 32'h0000_0880, 32'h0000_8002, 32'h0, 1'b0);
        one_return("R4", 1'b0, 2'd1, 32'h0000_0120, 32'h0, 32'h0000_8001, 1'b0);
        one_return("R4", 1'b1, 2'd3, 32'h0000_0880, 32'h0000_8002, 32'h0, 1'b1);
    endtask

    task automatic t_holdoff;
        @(negedge clk);
        drive(1'b1, 2'd3, 32'h0000_0880, 32'h0000_9000, 32'h0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "req_ready during result", XLEN'(req_ready), 0);
        // keep request up with new values: must wait one cycle
        drive(1'b0, 2'd1, 32'h0000_0120, 32'h0, 32'h0000_9100, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "res_valid gap", XLEN'(res_valid), 0);
        chk("R1", "req_ready after gap", XLEN'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        compare("R1", 1'b0, 2'd1, 32'h0000_0120, 32'h0, 32'h0000_9100, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "res_valid drops", XLEN'(res_valid), 0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 1'b0; cur_priv = 2'd0;
        status_in = '0; mepc = '0; sepc = '0; has_compressed = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mret();
        t_sret();
        t_illegal();
        t_align();
        t_holdoff();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule